// File: doc/BRIEF.md
# Must-Repair Fault Capture Analyzer

This block sits next to a memory self-test engine and takes at most one failing cell address (row and column) per clock. While the test runs it decides whether each fault leaves the array with no choice. A row that already holds as many recorded faults as there are spare columns cannot be fixed by columns alone, so it must take a spare row. The same holds for columns, with the number of spare rows as the limit. Such addresses go into a solution record of spare rows and spare columns. Faults that force nothing and that no recorded spare already covers are kept in a small fault list made of row and column CAMs. A later search can then read them back.

The fault list holds twice the product of the spare row and spare column counts. No repairable array can leave more uncovered faults than that. So a write into a full list, or a must-repair address with no spare left to take it, marks the array unrepairable at once, and the test may end early. The flag stays set until a synchronous clear, which also empties every store before the next test.

Top module: `mra_fault_capture`

## Requirements
- R1: After reset, or one cycle after `clear_i`, the fault count, the used-row count and the used-column count are zero. `overflow_o` and `unrepairable_o` are low, and every read port reports its entry as not valid.
- R2: An accepted fault that is not covered, not a duplicate and not must-repair is written to the lowest free fault-list entry. The entry is readable at that index on the cycle after it is written, and `fault_cnt_o` rises by one.
- R3: A fault whose row matches exactly SPC valid fault-list entries raises `row_must_o` in the same cycle. Its row goes into the next free spare-row slot, `used_rows_o` rises by one on the next cycle, and the fault itself is not stored.
- R4: A fault whose column matches exactly SPR valid fault-list entries raises `col_must_o` in the same cycle. Its column goes into the next free spare-column slot, `used_cols_o` rises by one, and the fault is not stored.
- R5: One fault can meet both conditions at once. In that case both flags rise and one row and one column are recorded in the same cycle.
- R6: A fault whose row is already in the spare-row record, or whose column is already in the spare-column record, changes no state and raises no flag.
- R7: A fault whose exact row and column pair is already in the fault list changes no state and raises no flag.
- R8: A fault that would be stored while the fault list holds 2·SPR·SPC entries sets `overflow_o` and `unrepairable_o`.
- R9: A must-repair row with all SPR spare rows used, or a must-repair column with all SPC spare columns used, sets `unrepairable_o` without touching that record.
- R10: Once `unrepairable_o` is set, it stays set and later faults change no count until `clear_i`.
- R11: While `test_done_i` is high, faults are ignored: no flag rises and no count changes.
- R12: Fault-list entries whose row or column is later promoted to must-repair stay stored and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all stores and flags |
| test_done_i | input | 1 | Test finished; faults are ignored |
| fault_valid_i | input | 1 | Fault address strobe |
| fault_row_i | input | ROW_W | Failing row address |
| fault_col_i | input | COL_W | Failing column address |
| row_must_o | output | 1 | Current fault makes its row must-repair |
| col_must_o | output | 1 | Current fault makes its column must-repair |
| used_rows_o | output | clog2(SPR+1) | Spare rows taken by must-repair |
| used_cols_o | output | clog2(SPC+1) | Spare columns taken by must-repair |
| fault_cnt_o | output | clog2(2·SPR·SPC+1) | Stored fault-list entries |
| overflow_o | output | 1 | Fault list overflowed (sticky) |
| unrepairable_o | output | 1 | Array cannot be repaired (sticky) |
| fl_rd_idx_i | input | idx(2·SPR·SPC) | Fault-list read index |
| fl_rd_row_o | output | ROW_W | Row of the indexed fault-list entry |
| fl_rd_col_o | output | COL_W | Column of the indexed fault-list entry |
| fl_rd_vld_o | output | 1 | Indexed fault-list entry is valid |
| sr_rd_idx_i | input | idx(SPR) | Spare-row record read index |
| sr_rd_row_o | output | ROW_W | Recorded spare-row address |
| sr_rd_vld_o | output | 1 | Indexed spare-row slot is valid |
| sc_rd_idx_i | input | idx(SPC) | Spare-column record read index |
| sc_rd_col_o | output | COL_W | Recorded spare-column address |
| sc_rd_vld_o | output | 1 | Indexed spare-column slot is valid |

## Verification
Directed sequences build each decision on purpose. Distinct rows and columns fill the list until it overflows. Rows and columns that share addresses reach the must-repair count one at a time, or both in one fault. Repeats, covered addresses, exhausted spares and a raised test-done check each show that a fault is ignored. Constrained random faults drawn from a narrow address space mix all outcomes, with a clear every few dozen faults. Because rows and columns collide often, these runs separate a count taken over all entries from one that skips entries, and a threshold of equal-to from one of greater-than. Read-port sweeps after each sequence compare the stored entries, both their contents and their order, with a bench model.

// File: rtl/mra_pkg.sv
package mra_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/mra_popcount.sv
module mra_popcount #(
  parameter int N = 4,
  parameter int W = 3
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + W'(bits_i[i]);
  end
endmodule

// File: rtl/mra_cam.sv
// Append-only CAM; valid bits fill in order so the count is the next free slot.
module mra_cam #(
  parameter int DEPTH = 2,
  parameter int KW    = 8,
  localparam int IW   = mra_pkg::idx_w(DEPTH),
  localparam int CW   = mra_pkg::cnt_w(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [KW-1:0]    key_i,
  output logic [DEPTH-1:0] match_o,
  output logic             full_o,
  output logic [CW-1:0]    count_o,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [KW-1:0]    rd_key_o,
  output logic             rd_vld_o
);
  logic [DEPTH-1:0] vld_q;
  logic [KW-1:0]    key_q [DEPTH];

  mra_popcount #(.N(DEPTH), .W(CW)) u_cnt (.bits_i(vld_q), .cnt_o(count_o));
  assign full_o = &vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) key_q[i] <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (wr_i && !full_o) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (count_o == CW'(i)) begin
          vld_q[i] <= 1'b1;
          key_q[i] <= key_i;
        end
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign match_o[g] = vld_q[g] && (key_q[g] == key_i);
  end

  always_comb begin
    rd_key_o = '0;
    rd_vld_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IW'(i)) begin
        rd_key_o = key_q[i];
        rd_vld_o = vld_q[i];
      end
    end
  end
endmodule

// File: rtl/mra_fault_list.sv
// Paired row/column CAM holding uncovered, non-forcing faults.
module mra_fault_list #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int IW   = mra_pkg::idx_w(DEPTH),
  localparam int CW   = mra_pkg::cnt_w(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [DEPTH-1:0] row_match_o,
  output logic [DEPTH-1:0] col_match_o,
  output logic [DEPTH-1:0] pair_match_o,
  output logic             full_o,
  output logic [CW-1:0]    count_o,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic             rd_vld_o
);
  logic [DEPTH-1:0] vld_q;
  logic [ROW_W-1:0] row_q [DEPTH];
  logic [COL_W-1:0] col_q [DEPTH];

  mra_popcount #(.N(DEPTH), .W(CW)) u_cnt (.bits_i(vld_q), .cnt_o(count_o));
  assign full_o = &vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        row_q[i] <= '0;
        col_q[i] <= '0;
      end
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (wr_i && !full_o) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (count_o == CW'(i)) begin
          vld_q[i] <= 1'b1;
          row_q[i] <= row_i;
          col_q[i] <= col_i;
        end
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign row_match_o[g]  = vld_q[g] && (row_q[g] == row_i);
    assign col_match_o[g]  = vld_q[g] && (col_q[g] == col_i);
    assign pair_match_o[g] = row_match_o[g] && col_match_o[g];
  end

  always_comb begin
    rd_row_o = '0;
    rd_col_o = '0;
    rd_vld_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IW'(i)) begin
        rd_row_o = row_q[i];
        rd_col_o = col_q[i];
        rd_vld_o = vld_q[i];
      end
    end
  end
endmodule

// File: rtl/mra_fault_capture.sv
module mra_fault_capture #(
  parameter int SPR   = 2,
  parameter int SPC   = 2,
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int FL_DEPTH = 2 * SPR * SPC,
  localparam int FIW = mra_pkg::idx_w(FL_DEPTH),
  localparam int FCW = mra_pkg::cnt_w(FL_DEPTH),
  localparam int RIW = mra_pkg::idx_w(SPR),
  localparam int RCW = mra_pkg::cnt_w(SPR),
  localparam int CIW = mra_pkg::idx_w(SPC),
  localparam int CCW = mra_pkg::cnt_w(SPC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             test_done_i,
  input  logic             fault_valid_i,
  input  logic [ROW_W-1:0] fault_row_i,
  input  logic [COL_W-1:0] fault_col_i,
  output logic             row_must_o,
  output logic             col_must_o,
  output logic [RCW-1:0]   used_rows_o,
  output logic [CCW-1:0]   used_cols_o,
  output logic [FCW-1:0]   fault_cnt_o,
  output logic             overflow_o,
  output logic             unrepairable_o,
  input  logic [FIW-1:0]   fl_rd_idx_i,
  output logic [ROW_W-1:0] fl_rd_row_o,
  output logic [COL_W-1:0] fl_rd_col_o,
  output logic             fl_rd_vld_o,
  input  logic [RIW-1:0]   sr_rd_idx_i,
  output logic [ROW_W-1:0] sr_rd_row_o,
  output logic             sr_rd_vld_o,
  input  logic [CIW-1:0]   sc_rd_idx_i,
  output logic [COL_W-1:0] sc_rd_col_o,
  output logic             sc_rd_vld_o
);
  logic [FL_DEPTH-1:0] fl_row_match, fl_col_match, fl_pair_match;
  logic                fl_full, fl_wr;
  logic [SPR-1:0]      sr_match;
  logic [SPC-1:0]      sc_match;
  logic                sr_full, sc_full, sr_wr, sc_wr;
  logic [FCW-1:0]      row_hits, col_hits;
  logic                fire, covered, dup, row_must, col_must, fresh;
  logic                spare_short, fl_ovf;
  logic                ovf_q, unrep_q;

  mra_fault_list #(.DEPTH(FL_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_fl (
    .clk_i, .rst_ni, .clr_i(clear_i), .wr_i(fl_wr),
    .row_i(fault_row_i), .col_i(fault_col_i),
    .row_match_o(fl_row_match), .col_match_o(fl_col_match), .pair_match_o(fl_pair_match),
    .full_o(fl_full), .count_o(fault_cnt_o),
    .rd_idx_i(fl_rd_idx_i), .rd_row_o(fl_rd_row_o), .rd_col_o(fl_rd_col_o), .rd_vld_o(fl_rd_vld_o)
  );

  mra_cam #(.DEPTH(SPR), .KW(ROW_W)) u_spare_rows (
    .clk_i, .rst_ni, .clr_i(clear_i), .wr_i(sr_wr), .key_i(fault_row_i),
    .match_o(sr_match), .full_o(sr_full), .count_o(used_rows_o),
    .rd_idx_i(sr_rd_idx_i), .rd_key_o(sr_rd_row_o), .rd_vld_o(sr_rd_vld_o)
  );

  mra_cam #(.DEPTH(SPC), .KW(COL_W)) u_spare_cols (
    .clk_i, .rst_ni, .clr_i(clear_i), .wr_i(sc_wr), .key_i(fault_col_i),
    .match_o(sc_match), .full_o(sc_full), .count_o(used_cols_o),
    .rd_idx_i(sc_rd_idx_i), .rd_key_o(sc_rd_col_o), .rd_vld_o(sc_rd_vld_o)
  );

  mra_popcount #(.N(FL_DEPTH), .W(FCW)) u_row_hits (.bits_i(fl_row_match), .cnt_o(row_hits));
  mra_popcount #(.N(FL_DEPTH), .W(FCW)) u_col_hits (.bits_i(fl_col_match), .cnt_o(col_hits));

  always_comb begin
    fire     = fault_valid_i && !test_done_i && !unrep_q && !clear_i;
    covered  = (|sr_match) || (|sc_match);
    dup      = |fl_pair_match;
    fresh    = fire && !covered && !dup;
    // a row with SPC stored faults plus this one exceeds what columns can fix
    row_must = fresh && (row_hits >= FCW'(SPC));
    col_must = fresh && (col_hits >= FCW'(SPR));
    sr_wr    = row_must && !sr_full;
    sc_wr    = col_must && !sc_full;
    spare_short = (row_must && sr_full) || (col_must && sc_full);
    fl_wr    = fresh && !row_must && !col_must && !fl_full;
    fl_ovf   = fresh && !row_must && !col_must && fl_full;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q   <= 1'b0;
      unrep_q <= 1'b0;
    end else if (clear_i) begin
      ovf_q   <= 1'b0;
      unrep_q <= 1'b0;
    end else begin
      if (fl_ovf) ovf_q <= 1'b1;
      if (fl_ovf || spare_short) unrep_q <= 1'b1;
    end
  end

  assign row_must_o     = row_must;
  assign col_must_o     = col_must;
  assign overflow_o     = ovf_q;
  assign unrepairable_o = unrep_q;
endmodule

// File: rtl/mra_fault_capture_chk.sv
module mra_fault_capture_chk #(
  parameter int SPR = 2,
  parameter int SPC = 2,
  localparam int FL_DEPTH = 2 * SPR * SPC,
  localparam int FCW = mra_pkg::cnt_w(FL_DEPTH),
  localparam int RCW = mra_pkg::cnt_w(SPR),
  localparam int CCW = mra_pkg::cnt_w(SPC)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           clear_i,
  input logic           test_done_i,
  input logic           fault_valid_i,
  input logic           row_must_o,
  input logic           col_must_o,
  input logic [RCW-1:0] used_rows_o,
  input logic [CCW-1:0] used_cols_o,
  input logic [FCW-1:0] fault_cnt_o,
  input logic           overflow_o,
  input logic           unrepairable_o
);
  // R1
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (fault_cnt_o == '0) && (used_rows_o == '0) && (used_cols_o == '0)
                && !overflow_o && !unrepairable_o);
  // R2
  must_needs_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_must_o || col_must_o) |-> fault_valid_i && !test_done_i && !clear_i);
  // R3
  row_must_takes_spare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_must_o && (used_rows_o < RCW'(SPR))) |=> used_rows_o == $past(used_rows_o) + RCW'(1));
  // R4
  col_must_takes_spare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_must_o && (used_cols_o < CCW'(SPC))) |=> used_cols_o == $past(used_cols_o) + CCW'(1));
  // R3
  must_not_listed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_must_o || col_must_o) |=> $stable(fault_cnt_o));
  // R8
  overflow_is_fatal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> unrepairable_o);
  // R10
  unrep_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unrepairable_o && !clear_i) |=> unrepairable_o && $stable(fault_cnt_o)
                                     && $stable(used_rows_o) && $stable(used_cols_o));
  // R11
  done_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_done_i && !clear_i) |=> $stable(fault_cnt_o) && $stable(used_rows_o)
                                  && $stable(used_cols_o));
endmodule

bind mra_fault_capture mra_fault_capture_chk #(.SPR(SPR), .SPC(SPC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .test_done_i(test_done_i),
  .fault_valid_i(fault_valid_i), .row_must_o(row_must_o), .col_must_o(col_must_o),
  .used_rows_o(used_rows_o), .used_cols_o(used_cols_o), .fault_cnt_o(fault_cnt_o),
  .overflow_o(overflow_o), .unrepairable_o(unrepairable_o)
);

// File: tb/mra_fault_capture_tb_top.sv
module mra_fault_capture_tb_top;
  localparam int SPR = 2, SPC = 2, ROW_W = 8, COL_W = 8;
  localparam int D = 2 * SPR * SPC;

  logic clk_i = 0, rst_ni = 0, clear_i = 0, test_done_i = 0, fault_valid_i = 0;
  logic [ROW_W-1:0] fault_row_i = '0;
  logic [COL_W-1:0] fault_col_i = '0;
  logic row_must_o, col_must_o, overflow_o, unrepairable_o;
  logic [1:0] used_rows_o, used_cols_o;
  logic [3:0] fault_cnt_o;
  logic [2:0] fl_rd_idx_i = '0;
  logic [ROW_W-1:0] fl_rd_row_o, sr_rd_row_o;
  logic [COL_W-1:0] fl_rd_col_o, sc_rd_col_o;
  logic fl_rd_vld_o, sr_rd_vld_o, sc_rd_vld_o;
  logic sr_rd_idx_i = 1'b0, sc_rd_idx_i = 1'b0;

  mra_fault_capture #(.SPR(SPR), .SPC(SPC), .ROW_W(ROW_W), .COL_W(COL_W)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model
  int m_fr[D], m_fc[D], m_sr[SPR], m_sc[SPC];
  int m_nfl, m_nr, m_nc;
  bit m_unrep, m_ovf, m_done;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_nfl = 0; m_nr = 0; m_nc = 0; m_unrep = 0; m_ovf = 0;
  endtask

  task automatic model_step(input int r, input int c, output bit erm, output bit ecm);
    bit cov, dupl;
    int rc, cc;
    erm = 0; ecm = 0; cov = 0; dupl = 0; rc = 0; cc = 0;
    if (m_done || m_unrep) return;
    for (int i = 0; i < m_nr; i++) if (m_sr[i] == r) cov = 1;
    for (int i = 0; i < m_nc; i++) if (m_sc[i] == c) cov = 1;
    if (cov) return;
    for (int i = 0; i < m_nfl; i++) begin
      if (m_fr[i] == r && m_fc[i] == c) dupl = 1;
      if (m_fr[i] == r) rc++;
      if (m_fc[i] == c) cc++;
    end
    if (dupl) return;
    erm = (rc >= SPC);
    ecm = (cc >= SPR);
    if (erm) begin
      if (m_nr < SPR) begin m_sr[m_nr] = r; m_nr++; end else m_unrep = 1;
    end
    if (ecm) begin
      if (m_nc < SPC) begin m_sc[m_nc] = c; m_nc++; end else m_unrep = 1;
    end
    if (!erm && !ecm) begin
      if (m_nfl < D) begin m_fr[m_nfl] = r; m_fc[m_nfl] = c; m_nfl++; end
      else begin m_ovf = 1; m_unrep = 1; end
    end
  endtask

  task automatic check_state(input string tag);
    chk(tag, "fault_cnt", int'(fault_cnt_o), m_nfl);
    chk(tag, "used_rows", int'(used_rows_o), m_nr);
    chk(tag, "used_cols", int'(used_cols_o), m_nc);
    chk(tag, "unrepairable", int'(unrepairable_o), int'(m_unrep));
    chk(tag, "overflow", int'(overflow_o), int'(m_ovf));
  endtask

  task automatic fault(input string tag, input int r, input int c);
    bit erm, ecm;
    @(negedge clk_i);
    fault_row_i = ROW_W'(r); fault_col_i = COL_W'(c); fault_valid_i = 1;
    #1;
    model_step(r, c, erm, ecm);
    chk(tag, "row_must", int'(row_must_o), int'(erm));
    chk(tag, "col_must", int'(col_must_o), int'(ecm));
    @(negedge clk_i);
    fault_valid_i = 0;
    #1;
    check_state(tag);
  endtask

  task automatic check_reads(input string tag);
    for (int i = 0; i < D; i++) begin
      fl_rd_idx_i = 3'(i); #1;
      chk(tag, "fl_vld", int'(fl_rd_vld_o), int'(i < m_nfl));
      if (i < m_nfl) begin
        chk(tag, "fl_row", int'(fl_rd_row_o), m_fr[i]);
        chk(tag, "fl_col", int'(fl_rd_col_o), m_fc[i]);
      end
    end
    for (int i = 0; i < SPR; i++) begin
      sr_rd_idx_i = 1'(i); #1;
      chk(tag, "sr_vld", int'(sr_rd_vld_o), int'(i < m_nr));
      if (i < m_nr) chk(tag, "sr_row", int'(sr_rd_row_o), m_sr[i]);
    end
    for (int i = 0; i < SPC; i++) begin
      sc_rd_idx_i = 1'(i); #1;
      chk(tag, "sc_vld", int'(sc_rd_vld_o), int'(i < m_nc));
      if (i < m_nc) chk(tag, "sc_col", int'(sc_rd_col_o), m_sc[i]);
    end
  endtask

  task automatic do_clear();
    @(negedge clk_i); clear_i = 1;
    @(negedge clk_i); clear_i = 0;
    model_reset();
    #1;
    check_state("R1");
    check_reads("R1");
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    model_reset(); m_done = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    check_state("R1");
    check_reads("R1");

    // R2: plain stores
    fault("R2", 1, 1);
    fault("R2", 2, 2);
    fault("R2", 1, 3);
    check_reads("R2");
    // R3: row 1 now holds SPC entries
    fault("R3", 1, 4);
    chk("R3", "row_recorded", int'(used_rows_o), 1);
    // R6: covered by recorded row
    fault("R6", 1, 9);
    // R12: row-1 entries stay listed
    check_reads("R12");
    // R4: column 6
    fault("R4", 3, 6);
    fault("R4", 4, 6);
    fault("R4", 7, 6);
    chk("R4", "col_recorded", int'(used_cols_o), 1);
    fault("R6", 8, 6);
    // R7: duplicate pair
    fault("R7", 2, 2);
    check_reads("R7");

    // R5: both at once
    do_clear();
    fault("R5", 1, 1); fault("R5", 1, 2); fault("R5", 3, 5); fault("R5", 4, 5);
    fault("R5", 1, 5);
    chk("R5", "both_recorded", int'(used_rows_o) + int'(used_cols_o), 2);
    check_reads("R5");

    // R9: third must-repair row with two spares
    do_clear();
    fault("R9", 1, 1); fault("R9", 1, 2); fault("R9", 1, 3);
    fault("R9", 2, 4); fault("R9", 2, 5); fault("R9", 2, 6);
    fault("R9", 3, 7); fault("R9", 3, 8); fault("R9", 3, 9);
    chk("R9", "unrepairable", int'(unrepairable_o), 1);
    // R10: frozen after unrepairable
    fault("R10", 10, 10);
    fault("R10", 11, 12);
    check_reads("R10");

    // R8: overflow
    do_clear();
    for (int i = 0; i < D; i++) fault("R8", 20 + i, 40 + i);
    fault("R8", 30, 50);
    chk("R8", "overflow", int'(overflow_o), 1);
    fault("R10", 31, 51);

    // R11: test done
    do_clear();
    fault("R11", 5, 5);
    @(negedge clk_i); test_done_i = 1; m_done = 1;
    fault("R11", 6, 6);
    fault("R11", 5, 7);
    @(negedge clk_i); test_done_i = 0; m_done = 0;
    check_reads("R11");

    // random mix over a narrow address space
    do_clear();
    for (int n = 0; n < 600; n++) begin
      if (n % 25 == 24) begin
        check_reads("RND");
        do_clear();
      end
      fault("RND", int'($urandom_range(0, 5)), int'($urandom_range(0, 5)));
    end
    check_reads("RND");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule